// File: doc/BRIEF.md
# Exception Priority and Vector Unit

This unit sits beside the fetch and execute stages of a small 32-bit processor core and decides which pending exception the core takes next. Each cycle it looks at the request lines from the core: data abort, fast interrupt, normal interrupt, prefetch abort, undefined instruction and software interrupt. It also looks at the core's current status word and the address of the current instruction. From these it selects at most one entry. One cycle later it raises an entry strobe together with the handler address, the mode code to enter and the status word the core loads.

On every entry other than reset, the unit writes the old status word and a return address into its own bank of saved-status and link registers. Each exception mode has its own pair. The core reads these back through a mode-indexed read port. After reset is released, the unit performs one reset entry by itself. A data abort that arrives together with an enabled fast interrupt produces two entries in back-to-back cycles. The fast-interrupt entry records the start of the abort handler as its return point, so a return from the fast-interrupt handler lands in the abort handler.

Top module: `exc_arbiter`

## Requirements
- R1: While `rst_n` is low, `take` is 0, `vec_addr` is 0x00, `enter_mode` is 10011 and `new_status` is 0x000000D3. In the first cycle after release, `take` is 1 with vector 0x00 and mode 10011. That reset entry sets status bits 7 and 6 and saves nothing in the banks.
- R2: The handler address is the base (0 by default) plus a fixed offset: 0x1C fast interrupt, 0x18 normal interrupt, 0x10 data abort, 0x0C prefetch abort, 0x08 software interrupt, 0x04 undefined instruction. The offset 0x14 is never produced.
- R3: `enter_mode` is 10001 for fast interrupt, 10010 for normal interrupt and 10111 for both abort kinds. It is 11011 for undefined instruction, and 10011 for software interrupt and reset.
- R4: When several enabled requests are present, the winner is picked in this order: data abort, then fast interrupt, then normal interrupt, then prefetch abort, then undefined instruction or software interrupt.
- R5: A fast-interrupt request is ignored while `cur_status` bit 6 is set. A normal-interrupt request is ignored while bit 7 is set. A masked request alone produces no entry.
- R6: Requests sampled at one rising edge appear as `take`=1 after the next edge, and `take` is high for exactly one cycle per entry.
- R7: The new status word is the old one with bits [4:0] replaced by the mode code, bit 7 set and bit 5 cleared. Bit 6 is also set on reset and fast-interrupt entries and kept otherwise. Bits 31:8 are kept.
- R8: On an entry, the saved-status register of the entered mode receives the old status word, and its link register receives the return address. Both are read on `bank_lr`/`bank_spsr` by putting the mode code on `bank_sel`.
- R9: The return address is `cur_pc` + 4 for software interrupt and undefined instruction, and `cur_pc` for the other requests.
- R10: A data abort together with a fast interrupt whose bit 6 is clear gives the abort entry, then a fast-interrupt entry in the very next cycle. For that fast-interrupt entry, the saved status is the status the abort entry produced and the link value is the abort handler address. Any other request during that second cycle is not taken in it.
- R11: Undefined-instruction and software-interrupt requests are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| dabt_req | input | 1 | Data abort request |
| fiq_req | input | 1 | Fast interrupt request |
| irq_req | input | 1 | Normal interrupt request |
| pabt_req | input | 1 | Prefetch abort request |
| und_req | input | 1 | Undefined instruction request |
| swi_req | input | 1 | Software interrupt request |
| cur_status | input | 32 | Current status word (bit 7 I mask, bit 6 F mask, bit 5 state, [4:0] mode) |
| cur_pc | input | 32 | Address of the current instruction |
| bank_sel | input | 5 | Mode code selecting the bank to read |
| take | output | 1 | One-cycle entry strobe |
| vec_addr | output | 32 | Handler address of the entry |
| enter_mode | output | 5 | Mode code of the entry |
| new_status | output | 32 | Status word to load on entry |
| bank_lr | output | 32 | Link register of the selected mode |
| bank_spsr | output | 32 | Saved status of the selected mode |

## Verification
The arbitration is exercised with single requests of each kind, and with pairs of requests that share adjacent priority levels, so that each step of the order is compared on its own. Masked requests are sent alone and beside lower-priority requests. This separates "ignored" from "outranked". Reading the bank after every entry tells a wrong return offset apart from a wrong bank slot. The coincident abort and fast-interrupt case is run with a normal interrupt held high as well, which shows that the chained second entry cannot be taken over by another request.

// File: rtl/exc_arbiter.sv
module exc_arbiter #(
  parameter logic [31:0] VEC_BASE   = 32'h0,
  parameter int unsigned INSN_BYTES = 4,
  parameter int unsigned I_POS      = 7,
  parameter int unsigned F_POS      = 6,
  parameter int unsigned T_POS      = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        dabt_req,
  input  logic        fiq_req,
  input  logic        irq_req,
  input  logic        pabt_req,
  input  logic        und_req,
  input  logic        swi_req,
  input  logic [31:0] cur_status,
  input  logic [31:0] cur_pc,
  input  logic [4:0]  bank_sel,
  output logic        take,
  output logic [31:0] vec_addr,
  output logic [4:0]  enter_mode,
  output logic [31:0] new_status,
  output logic [31:0] bank_lr,
  output logic [31:0] bank_spsr
);
  localparam logic [4:0] M_SVC = 5'b10011;
  localparam logic [4:0] M_UND = 5'b11011;
  localparam logic [4:0] M_ABT = 5'b10111;
  localparam logic [4:0] M_IRQ = 5'b10010;
  localparam logic [4:0] M_FIQ = 5'b10001;
  localparam int unsigned NBANK = 5;
  localparam logic [31:0] RST_STATUS =
    32'(M_SVC) | (32'd1 << I_POS) | (32'd1 << F_POS);

  typedef enum logic [3:0] {
    K_NONE, K_RST, K_CHAIN, K_DABT, K_FIQ, K_IRQ, K_PABT, K_UND, K_SWI
  } kind_t;

  function automatic logic [2:0] slot_of(input logic [4:0] m);
    case (m)
      M_SVC:   slot_of = 3'd0;
      M_UND:   slot_of = 3'd1;
      M_ABT:   slot_of = 3'd2;
      M_IRQ:   slot_of = 3'd3;
      M_FIQ:   slot_of = 3'd4;
      default: slot_of = 3'd7;
    endcase
  endfunction

  logic        rst_pend, chain_pend;
  logic [31:0] lr_bank   [NBANK];
  logic [31:0] spsr_bank [NBANK];

  logic  fiq_ok, irq_ok;
  kind_t kind;
  logic [7:0]  offs;
  logic [4:0]  tgt_mode;
  logic [31:0] ret_addr, old_st, nxt_st;
  logic        set_f, save;
  logic [2:0]  wr_slot, rd_slot;

  assign fiq_ok = fiq_req & ~cur_status[F_POS];
  assign irq_ok = irq_req & ~cur_status[I_POS];

  always_comb begin
    if (rst_pend)        kind = K_RST;
    else if (chain_pend) kind = K_CHAIN;
    else if (dabt_req)   kind = K_DABT;
    else if (fiq_ok)     kind = K_FIQ;
    else if (irq_ok)     kind = K_IRQ;
    else if (pabt_req)   kind = K_PABT;
    else if (und_req)    kind = K_UND;
    else if (swi_req)    kind = K_SWI;
    else                 kind = K_NONE;
  end

  always_comb begin
    offs     = 8'h00;
    tgt_mode = M_SVC;
    ret_addr = cur_pc;
    old_st   = cur_status;
    set_f    = 1'b0;
    save     = 1'b1;
    case (kind)
      K_RST:   begin set_f = 1'b1; save = 1'b0; end
      K_CHAIN: begin
        offs = 8'h1C; tgt_mode = M_FIQ; set_f = 1'b1;
        old_st = new_status; ret_addr = VEC_BASE + 32'h10;
      end
      K_DABT:  begin offs = 8'h10; tgt_mode = M_ABT; end
      K_FIQ:   begin offs = 8'h1C; tgt_mode = M_FIQ; set_f = 1'b1; end
      K_IRQ:   begin offs = 8'h18; tgt_mode = M_IRQ; end
      K_PABT:  begin offs = 8'h0C; tgt_mode = M_ABT; end
      K_UND:   begin
        offs = 8'h04; tgt_mode = M_UND; ret_addr = cur_pc + 32'(INSN_BYTES);
      end
      K_SWI:   begin
        offs = 8'h08; tgt_mode = M_SVC; ret_addr = cur_pc + 32'(INSN_BYTES);
      end
      default: save = 1'b0;
    endcase
  end

  always_comb begin
    nxt_st        = old_st;
    nxt_st[4:0]   = tgt_mode;
    nxt_st[I_POS] = 1'b1;
    nxt_st[T_POS] = 1'b0;
    if (set_f) nxt_st[F_POS] = 1'b1;
  end

  assign wr_slot = slot_of(tgt_mode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pend   <= 1'b1;
      chain_pend <= 1'b0;
      take       <= 1'b0;
      vec_addr   <= VEC_BASE;
      enter_mode <= M_SVC;
      new_status <= RST_STATUS;
      for (int i = 0; i < NBANK; i++) begin
        lr_bank[i]   <= '0;
        spsr_bank[i] <= '0;
      end
    end else begin
      rst_pend   <= 1'b0;
      chain_pend <= (kind == K_DABT) && fiq_ok;
      take       <= (kind != K_NONE);
      if (kind != K_NONE) begin
        vec_addr   <= VEC_BASE + 32'(offs);
        enter_mode <= tgt_mode;
        new_status <= nxt_st;
      end
      if (save && wr_slot < 3'(NBANK)) begin
        lr_bank[wr_slot]   <= ret_addr;
        spsr_bank[wr_slot] <= old_st;
      end
    end
  end

  assign rd_slot   = slot_of(bank_sel);
  assign bank_lr   = (rd_slot < 3'(NBANK)) ? lr_bank[rd_slot]   : '0;
  assign bank_spsr = (rd_slot < 3'(NBANK)) ? spsr_bank[rd_slot] : '0;
endmodule

module exc_arbiter_chk #(
  parameter logic [31:0] VEC_BASE = 32'h0
) (
  input logic        clk,
  input logic        rst_n,
  input logic        dabt_req,
  input logic        fiq_req,
  input logic        irq_req,
  input logic        pabt_req,
  input logic        und_req,
  input logic        swi_req,
  input logic [31:0] cur_status,
  input logic        take,
  input logic [31:0] vec_addr,
  input logic [4:0]  enter_mode,
  input logic [31:0] new_status,
  input logic        rst_pend,
  input logic        chain_pend
);
  // R2
  no_reserved_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> vec_addr != VEC_BASE + 32'h14);

  // R7
  entry_masks_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> new_status[7] && !new_status[5] && new_status[4:0] == enter_mode);

  // R7
  fiq_masks_fiq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && enter_mode == 5'b10001) |-> new_status[6]);

  // R5
  masked_irq_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && cur_status[7] && !dabt_req && !fiq_req && !pabt_req &&
     !und_req && !swi_req && !rst_pend && !chain_pend) |=> !take);

  // R10
  abort_then_fiq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dabt_req && fiq_req && !cur_status[6] && !rst_pend && !chain_pend)
    |=> (take && vec_addr == VEC_BASE + 32'h10) ##1
        (take && vec_addr == VEC_BASE + 32'h1C && enter_mode == 5'b10001));

  // R11
  und_swi_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(und_req && swi_req));
endmodule

bind exc_arbiter exc_arbiter_chk #(.VEC_BASE(VEC_BASE)) u_chk (
  .clk(clk), .rst_n(rst_n), .dabt_req(dabt_req), .fiq_req(fiq_req),
  .irq_req(irq_req), .pabt_req(pabt_req), .und_req(und_req),
  .swi_req(swi_req), .cur_status(cur_status), .take(take),
  .vec_addr(vec_addr), .enter_mode(enter_mode), .new_status(new_status),
  .rst_pend(rst_pend), .chain_pend(chain_pend)
);

// File: tb/exc_arbiter_test.sv
module exc_arbiter_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dabt_req = 0, fiq_req = 0, irq_req = 0, pabt_req = 0, und_req = 0, swi_req = 0;
  logic [31:0] cur_status = '0, cur_pc = '0;
  logic [4:0]  bank_sel = 5'b10011;
  logic        take;
  logic [31:0] vec_addr, new_status, bank_lr, bank_spsr;
  logic [4:0]  enter_mode;

  int checks = 0, errors = 0;
  bit done = 0;

  exc_arbiter uut (
    .clk(clk), .rst_n(rst_n), .dabt_req(dabt_req), .fiq_req(fiq_req),
    .irq_req(irq_req), .pabt_req(pabt_req), .und_req(und_req),
    .swi_req(swi_req), .cur_status(cur_status), .cur_pc(cur_pc),
    .bank_sel(bank_sel), .take(take), .vec_addr(vec_addr),
    .enter_mode(enter_mode), .new_status(new_status),
    .bank_lr(bank_lr), .bank_spsr(bank_spsr)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  // request order {dabt, fiq, irq, pabt, und, swi}
  typedef struct packed {
    logic [5:0] req;
    logic [7:0] st;
    logic       etake;
    logic [7:0] evec;
    logic [4:0] emode;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t TBL [NV] = '{
    '{6'b001000, 8'h10, 1'b1, 8'h18, 5'b10010},
    '{6'b001000, 8'h90, 1'b0, 8'h00, 5'b00000},
    '{6'b010000, 8'h10, 1'b1, 8'h1C, 5'b10001},
    '{6'b010000, 8'h50, 1'b0, 8'h00, 5'b00000},
    '{6'b011000, 8'h10, 1'b1, 8'h1C, 5'b10001},
    '{6'b011000, 8'h50, 1'b1, 8'h18, 5'b10010},
    '{6'b001100, 8'h10, 1'b1, 8'h18, 5'b10010},
    '{6'b000110, 8'h10, 1'b1, 8'h0C, 5'b10111},
    '{6'b000010, 8'h10, 1'b1, 8'h04, 5'b11011},
    '{6'b000001, 8'h10, 1'b1, 8'h08, 5'b10011},
    '{6'b001001, 8'h90, 1'b1, 8'h08, 5'b10011},
    '{6'b100000, 8'h10, 1'b1, 8'h10, 5'b10111},
    '{6'b110000, 8'h50, 1'b1, 8'h10, 5'b10111}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [5:0] r);
    {dabt_req, fiq_req, irq_req, pabt_req, und_req, swi_req} = r;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // R1: values held during reset
    repeat (2) @(negedge clk);
    chk("R1 take in reset", 32'(take), 32'h0);
    chk("R1 vector in reset", vec_addr, 32'h0);
    chk("R1 mode in reset", 32'(enter_mode), 32'h13);
    chk("R1 status in reset", new_status, 32'hD3);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset entry strobe", 32'(take), 32'h1);
    chk("R1 reset entry vector", vec_addr, 32'h0);
    chk("R1 reset entry status", new_status, 32'hD3);
    bank_sel = 5'b10011;
    #1 chk("R1 reset saves nothing", bank_lr, 32'h0);
    @(negedge clk);
    chk("R6 strobe drops after reset entry", 32'(take), 32'h0);

    // table walk: R2 R3 R4 R5 R6 R7 R8 R9
    for (int i = 0; i < NV; i++) begin
      logic [31:0] pc, exp_lr, exp_st;
      pc = 32'h0000_1000 + 32'(i) * 32'h40;
      cur_pc = pc;
      cur_status = 32'(TBL[i].st);
      bank_sel = TBL[i].emode;
      drive(TBL[i].req);
      @(negedge clk);
      drive(6'b0);
      chk($sformatf("R5 R6 take v%0d", i), 32'(take), 32'(TBL[i].etake));
      if (TBL[i].etake) begin
        chk($sformatf("R2 R4 vector v%0d", i), vec_addr, 32'(TBL[i].evec));
        chk($sformatf("R3 mode v%0d", i), 32'(enter_mode), 32'(TBL[i].emode));
        exp_st = {24'h0, 1'b1, TBL[i].st[6] | (TBL[i].emode == 5'b10001), 1'b0, TBL[i].emode};
        chk($sformatf("R7 status v%0d", i), new_status, exp_st);
        exp_lr = (TBL[i].evec == 8'h04 || TBL[i].evec == 8'h08) ? pc + 32'd4 : pc;
        #1;
        chk($sformatf("R9 link v%0d", i), bank_lr, exp_lr);
        chk($sformatf("R8 saved status v%0d", i), bank_spsr, 32'(TBL[i].st));
      end
      @(negedge clk);
      chk($sformatf("R6 R10 single entry v%0d", i), 32'(take), 32'h0);
    end

    // R10: coincident abort and enabled fast interrupt, irq held too
    cur_pc = 32'h0000_2000;
    cur_status = 32'h10;
    drive(6'b111000);
    bank_sel = 5'b10111;
    @(negedge clk);
    chk("R10 first entry vector", vec_addr, 32'h10);
    chk("R10 first entry mode", 32'(enter_mode), 32'h17);
    #1 chk("R10 abort link", bank_lr, 32'h2000);
    bank_sel = 5'b10001;
    @(negedge clk);
    drive(6'b0);
    chk("R10 chained strobe", 32'(take), 32'h1);
    chk("R10 chained vector", vec_addr, 32'h1C);
    chk("R10 chained status", new_status, 32'hD1);
    #1;
    chk("R10 fiq link is abort handler", bank_lr, 32'h10);
    chk("R10 fiq saved status", bank_spsr, 32'h97);
    @(negedge clk);
    chk("R10 chain ends", 32'(take), 32'h0);

    // R1: reset in the middle overrides a pending request
    cur_status = 32'h10;
    drive(6'b001000);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 reset overrides request", 32'(take), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    drive(6'b0);
    chk("R1 reset entry first", vec_addr, 32'h0);
    chk("R1 reset entry mode", 32'(enter_mode), 32'h13);

    finish_run();
  end
endmodule